// File: doc/BRIEF.md
# Segment Access Protection Checker

This block judges a single memory access against an already decoded segment descriptor. Each request carries the segment base, a 20-bit limit, the descriptor's access byte and flag nibble. It also carries the offset being touched, the access width, the kind of access (read, write or instruction fetch) and the privilege level the requester runs at. One clock after the request is captured, the block returns either the 32-bit linear address or a fault code that says why the access was refused.

The checks cover several rules. The limit is scaled by the granularity flag. The bound test flips for data segments that grow downward. Code and data segments follow different permission rules, and data segments carry a privilege check. Faults have a fixed priority, so a request that breaks several rules always reports the same one. The block holds no descriptor state. The pipeline that calls it supplies a complete description of the access every cycle that `reqValid` is high.

Top module: `seg_guard`

## Requirements
- R1: A request taken on a rising edge with `reqValid` high gives `rspValid` high after that edge, and only then. `rspValid` is low after any edge where `reqValid` was low. Reset drives `rspValid`, `rspFault`, `rspCode` and `rspAddr` to zero.
- R2: The access byte is laid out as follows. Bit 7 is present. Bits 6:5 are the descriptor privilege. Bit 4 must be 1. Bit 3 marks code. Bit 2 is grow-down (data only). Bit 1 is readable for code or writable for data. Bit 0 is ignored. A request whose present bit is 0 faults with code 1.
- R3: Bit 4 of the access byte at 0 gives type fault code 2. So does a request kind of 3. Kinds are encoded as read 0, write 1, fetch 2.
- R4: For a code segment, writes fault with code 2. Reads fault with code 2 unless bit 1 is set. Fetches are allowed.
- R5: For a data segment, reads are allowed. Writes fault with code 2 unless bit 1 is set. Fetches fault with code 2.
- R6: For a data segment, a requester privilege numerically greater than the descriptor privilege faults with code 3. Code segments get no privilege check.
- R7: With flag bit 3 (granularity) at 0, the limit counts bytes. The access spans 2^`reqSize` bytes (`reqSize` 0..3 gives 1, 2, 4 or 8). On a grow-up segment, a last byte (offset + span - 1, without wrapping) above the limit faults with code 4.
- R8: With flag bit 3 at 1, the effective limit is limit·4096 + 4095. A limit of 0xFFFFF then admits every offset whose last byte stays below 2^32.
- R9: A grow-down data segment needs the offset to be strictly greater than the effective limit. It also needs the last byte to stay at or below 0xFFFF when flag bit 2 (size) is 0, or at or below 0xFFFFFFFF when flag bit 2 is 1. Otherwise it faults with code 4.
- R10: When several faults apply, the code reported is the first that applies in this order: not-present (1), type (2), privilege (3), limit (4).
- R11: A granted access reports `rspFault` 0, `rspCode` 0 and `rspAddr` = base + offset modulo 2^32. A faulted access reports `rspFault` 1 and `rspAddr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| descBase | input | 32 | Segment base address |
| descLimit | input | 20 | Raw segment limit |
| descAccess | input | 8 | Descriptor access byte |
| descFlags | input | 4 | Flag nibble: bit 3 granularity, bit 2 size |
| reqOffset | input | 32 | Offset being accessed |
| reqSize | input | 2 | Log2 of access width in bytes |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| cpl | input | 2 | Requester privilege level |
| rspValid | output | 1 | Result valid |
| rspFault | output | 1 | Access refused |
| rspCode | output | 3 | 0 granted, 1 absent, 2 type, 3 privilege, 4 limit |
| rspAddr | output | 32 | Linear address, zero on fault |

## Verification
Every result of this block arrives exactly one rising edge after the request is captured. The bench drives each request on a falling edge and reads `rspValid`, `rspFault`, `rspCode` and `rspAddr` on the next falling edge, half a cycle after the register updates. The one-cycle pulse of `rspValid` is checked by idling a cycle after a request and confirming the flag has dropped on the falling edge after that. The fault priority and the limit boundaries are each probed with requests placed one byte either side of the edge.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  // Access byte bit positions
  localparam int ACC_PRESENT = 7;
  localparam int ACC_DPL_HI  = 6;
  localparam int ACC_DPL_LO  = 5;
  localparam int ACC_SEGBIT  = 4;
  localparam int ACC_CODE    = 3;
  localparam int ACC_DIRCONF = 2;
  localparam int ACC_RDWR    = 1;

  // Flag nibble bit positions
  localparam int FLG_GRAN = 3;
  localparam int FLG_SIZE = 2;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_ABSENT = 3'd1,
    FC_TYPE   = 3'd2,
    FC_PRIV   = 3'd3,
    FC_LIMIT  = 3'd4
  } faultCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic absent;
    logic typeBad;
    logic privBad;
    logic growDown;
    logic pageGran;
    logic wideTop;
  } strobe_t;

endpackage

// File: rtl/seg_guard_ctrl.sv
module seg_guard_ctrl
  import seg_guard_pkg::*;
(
  input  logic [7:0] descAccess,
  input  logic [3:0] descFlags,
  input  logic [1:0] reqKind,
  input  logic [1:0] cpl,
  output strobe_t    strobes
);

  reqKind_e   kindE;
  logic       isPresent;
  logic       isSegment;
  logic       isCode;
  logic       dirConf;
  logic       rdWr;
  logic [1:0] dpl;
  logic       codeBad;
  logic       dataBad;
  logic       unusedBits;

  assign kindE     = reqKind_e'(reqKind);
  assign isPresent = descAccess[ACC_PRESENT];
  assign dpl       = descAccess[ACC_DPL_HI:ACC_DPL_LO];
  assign isSegment = descAccess[ACC_SEGBIT];
  assign isCode    = descAccess[ACC_CODE];
  assign dirConf   = descAccess[ACC_DIRCONF];
  assign rdWr      = descAccess[ACC_RDWR];

  // accessed bit and low flag bits play no part in the decision
  assign unusedBits = ^{descAccess[0], descFlags[1:0]};

  // code: fetch ok, read needs readable, write never
  always_comb begin
    unique case (kindE)
      KIND_READ:  codeBad = !rdWr;
      KIND_WRITE: codeBad = 1'b1;
      KIND_EXEC:  codeBad = 1'b0;
      default:    codeBad = 1'b1;
    endcase
  end

  // data: read ok, write needs writable, fetch never
  always_comb begin
    unique case (kindE)
      KIND_READ:  dataBad = 1'b0;
      KIND_WRITE: dataBad = !rdWr;
      KIND_EXEC:  dataBad = 1'b1;
      default:    dataBad = 1'b1;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.absent   = !isPresent;
    strobes.typeBad  = !isSegment || (isCode ? codeBad : dataBad);
    strobes.privBad  = !isCode && (cpl > dpl);
    strobes.growDown = !isCode && dirConf;
    strobes.pageGran = descFlags[FLG_GRAN];
    strobes.wideTop  = descFlags[FLG_SIZE];
  end

endmodule

// File: rtl/seg_guard_bound.sv
module seg_guard_bound #(
  parameter int ADDR_W     = 32,
  parameter int LIM_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = 2
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [LIM_W-1:0]  limit,
  input  logic [SIZE_W-1:0] sizeLog,
  input  logic              pageGran,
  input  logic              growDown,
  input  logic              wideTop,
  output logic              outOfRange
);

  localparam int SCALED_W = LIM_W + PAGE_SHIFT;
  localparam logic [ADDR_W:0] ONE_X      = (ADDR_W+1)'(1);
  localparam logic [ADDR_W:0] NARROW_TOP = (ADDR_W+1)'(16'hFFFF);
  localparam logic [ADDR_W:0] WIDE_TOP   = {1'b0, {ADDR_W{1'b1}}};

  logic [SCALED_W-1:0] pageLim;
  logic [ADDR_W-1:0]   pageLimW;
  logic [ADDR_W-1:0]   byteLimW;
  logic [ADDR_W-1:0]   effLim;
  logic [ADDR_W:0]     spanM1;
  logic [ADDR_W:0]     lastByte;
  logic [ADDR_W:0]     topVal;
  logic                upBad;
  logic                downBad;

  assign pageLim  = {limit, {PAGE_SHIFT{1'b1}}};
  assign byteLimW = {{(ADDR_W-LIM_W){1'b0}}, limit};

  // fit the scaled limit to the address width
  generate
    if (SCALED_W >= ADDR_W) begin : gTrim
      assign pageLimW = pageLim[ADDR_W-1:0];
    end else begin : gPad
      assign pageLimW = {{(ADDR_W-SCALED_W){1'b0}}, pageLim};
    end
  endgenerate

  assign effLim   = pageGran ? pageLimW : byteLimW;
  assign spanM1   = (ONE_X << sizeLog) - ONE_X;
  assign lastByte = {1'b0, offset} + spanM1;
  assign topVal   = wideTop ? WIDE_TOP : NARROW_TOP;

  assign upBad   = lastByte > {1'b0, effLim};
  assign downBad = ({1'b0, offset} <= {1'b0, effLim}) || (lastByte > topVal);

  assign outOfRange = growDown ? downBad : upBad;

endmodule

// File: rtl/seg_guard_dp.sv
module seg_guard_dp
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIM_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] sizeLog,
  input  strobe_t           strobes,
  output logic              rspValid,
  output logic              rspFault,
  output logic [2:0]        rspCode,
  output logic [ADDR_W-1:0] rspAddr
);

  logic              outOfRange;
  faultCode_e        nextCode;
  logic [ADDR_W-1:0] linSum;

  seg_guard_bound #(
    .ADDR_W    (ADDR_W),
    .LIM_W     (LIM_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .SIZE_W    (SIZE_W)
  ) u_bound (
    .offset    (offset),
    .limit     (limit),
    .sizeLog   (sizeLog),
    .pageGran  (strobes.pageGran),
    .growDown  (strobes.growDown),
    .wideTop   (strobes.wideTop),
    .outOfRange(outOfRange)
  );

  assign linSum = base + offset;

  // fixed fault priority
  always_comb begin
    if (strobes.absent)       nextCode = FC_ABSENT;
    else if (strobes.typeBad) nextCode = FC_TYPE;
    else if (strobes.privBad) nextCode = FC_PRIV;
    else if (outOfRange)      nextCode = FC_LIMIT;
    else                      nextCode = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCode  <= 3'd0;
      rspAddr  <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspCode  <= nextCode;
        rspFault <= (nextCode != FC_NONE);
        rspAddr  <= (nextCode == FC_NONE) ? linSum : '0;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rspValid == $past(reqValid))); // R1

  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && reqValid && strobes.absent) |-> (rspFault && rspCode == 3'd1)); // R10

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspAddr == '0)); // R11

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIM_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  input  logic [7:0]        descAccess,
  input  logic [3:0]        descFlags,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        cpl,
  output logic              rspValid,
  output logic              rspFault,
  output logic [2:0]        rspCode,
  output logic [ADDR_W-1:0] rspAddr
);

  strobe_t strobes;

  seg_guard_ctrl u_ctrl (
    .descAccess(descAccess),
    .descFlags (descFlags),
    .reqKind   (reqKind),
    .cpl       (cpl),
    .strobes   (strobes)
  );

  seg_guard_dp #(
    .ADDR_W    (ADDR_W),
    .LIM_W     (LIM_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .SIZE_W    (SIZE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .base    (descBase),
    .limit   (descLimit),
    .offset  (reqOffset),
    .sizeLog (reqSize),
    .strobes (strobes),
    .rspValid(rspValid),
    .rspFault(rspFault),
    .rspCode (rspCode),
    .rspAddr (rspAddr)
  );

  AST_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && reqValid && descAccess[7] && descAccess[4] && descAccess[3] && reqKind == 2'd1)
      |-> (rspFault && rspCode == 3'd2)); // R4

  AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && reqValid && descAccess[7] && descAccess[4] && !descAccess[3] && reqKind == 2'd2)
      |-> (rspFault && rspCode == 3'd2)); // R5

endmodule

// File: tb/seg_guard_tb.sv
`timescale 1ns/1ps
module seg_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] descBase = '0;
  logic [19:0] descLimit = '0;
  logic [7:0]  descAccess = '0;
  logic [3:0]  descFlags = '0;
  logic [31:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [1:0]  reqKind = '0;
  logic [1:0]  cpl = '0;
  logic        rspValid;
  logic        rspFault;
  logic [2:0]  rspCode;
  logic [31:0] rspAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .descBase(descBase), .descLimit(descLimit), .descAccess(descAccess),
    .descFlags(descFlags), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqKind(reqKind), .cpl(cpl),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspAddr(rspAddr)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, RS = 2'd3;

  function automatic logic [7:0] acc(input logic p, input logic [1:0] dpl,
                                     input logic code, input logic dc, input logic rw);
    return {p, dpl, 1'b1, code, dc, rw, 1'b0};
  endfunction

  function automatic logic [3:0] flg(input logic g, input logic s);
    return {g, s, 2'b00};
  endfunction

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // drive on a falling edge, read one full cycle later
  task automatic runReq(input logic [31:0] b, input logic [19:0] l, input logic [7:0] a,
                        input logic [3:0] f, input logic [31:0] o, input logic [1:0] sz,
                        input logic [1:0] k, input logic [1:0] c, input logic [2:0] expCode,
                        input string tag);
    logic [31:0] expAddr;
    expAddr = (expCode == 3'd0) ? (b + o) : 32'd0;
    reqValid = 1'b1; descBase = b; descLimit = l; descAccess = a; descFlags = f;
    reqOffset = o; reqSize = sz; reqKind = k; cpl = c;
    @(negedge clk);
    reqValid = 1'b0;
    if (!rspValid || rspFault != (expCode != 3'd0) || rspCode != expCode || rspAddr != expAddr) begin
      checks++;
      errors++;
      $display("FAIL %s actual=v%0d f%0d c%0d a%h expected=v1 f%0d c%0d a%h", tag,
               rspValid, rspFault, rspCode, rspAddr, (expCode != 3'd0), expCode, expAddr);
    end else begin
      checks++;
    end
  endtask

  task automatic testReset;
    note(rspValid == 1'b0, "R1", "reset valid", 32'(rspValid), 32'd0);
    note(rspFault == 1'b0 && rspCode == 3'd0, "R1", "reset code", 32'(rspCode), 32'd0);
    note(rspAddr == 32'd0, "R1", "reset addr", rspAddr, 32'd0);
  endtask

  task automatic testLatency;
    runReq(32'h1000, 20'hFFFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'h10, 2'd2, RD, 2'd0, 3'd0, "R1 pulse");
    @(negedge clk);
    note(rspValid == 1'b0, "R1", "valid drops", 32'(rspValid), 32'd0);
  endtask

  task automatic testAbsent;
    runReq(32'h0, 20'h0, acc(0, 0, 0, 0, 0), flg(0, 0), 32'hFFFF_0000, 2'd3, EX, 2'd3, 3'd1, "R2 absent");
    runReq(32'h2000, 20'hFFF, acc(0, 3, 1, 0, 1), flg(0, 1), 32'h4, 2'd0, EX, 2'd0, 3'd1, "R2 absent code");
    // accessed bit has no effect
    runReq(32'h2000, 20'hFFF, acc(1, 0, 0, 0, 1) | 8'h01, flg(0, 1), 32'h4, 2'd0, RD, 2'd0, 3'd0, "R2 accessed");
  endtask

  task automatic testType;
    runReq(32'h0, 20'hFFFFF, acc(1, 0, 0, 0, 1) & 8'hEF, flg(1, 1), 32'h4, 2'd0, RD, 2'd0, 3'd2, "R3 system");
    runReq(32'h0, 20'hFFFFF, acc(1, 0, 0, 0, 1), flg(1, 1), 32'h4, 2'd0, RS, 2'd0, 3'd2, "R3 kind3");
  endtask

  task automatic testCode;
    runReq(32'h100, 20'hFFFF, acc(1, 0, 1, 0, 1), flg(0, 1), 32'h20, 2'd2, RD, 2'd3, 3'd0, "R4 read ok");
    runReq(32'h100, 20'hFFFF, acc(1, 0, 1, 0, 0), flg(0, 1), 32'h20, 2'd2, RD, 2'd0, 3'd2, "R4 read denied");
    runReq(32'h100, 20'hFFFF, acc(1, 0, 1, 0, 1), flg(0, 1), 32'h20, 2'd2, WR, 2'd0, 3'd2, "R4 write");
    runReq(32'h100, 20'hFFFF, acc(1, 0, 1, 0, 0), flg(0, 1), 32'h20, 2'd0, EX, 2'd0, 3'd0, "R4 fetch");
  endtask

  task automatic testData;
    runReq(32'h4000, 20'hFFF, acc(1, 0, 0, 0, 0), flg(0, 1), 32'h8, 2'd2, RD, 2'd0, 3'd0, "R5 read");
    runReq(32'h4000, 20'hFFF, acc(1, 0, 0, 0, 0), flg(0, 1), 32'h8, 2'd2, WR, 2'd0, 3'd2, "R5 write ro");
    runReq(32'h4000, 20'hFFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'h8, 2'd2, WR, 2'd0, 3'd0, "R5 write rw");
    runReq(32'h4000, 20'hFFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'h8, 2'd0, EX, 2'd0, 3'd2, "R5 fetch");
  endtask

  task automatic testPriv;
    runReq(32'h0, 20'hFFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'h8, 2'd0, RD, 2'd3, 3'd3, "R6 cpl3 dpl0");
    runReq(32'h0, 20'hFFF, acc(1, 2, 0, 0, 1), flg(0, 1), 32'h8, 2'd0, RD, 2'd2, 3'd0, "R6 equal");
    runReq(32'h0, 20'hFFF, acc(1, 3, 0, 0, 1), flg(0, 1), 32'h8, 2'd0, RD, 2'd0, 3'd0, "R6 cpl0 dpl3");
    runReq(32'h0, 20'hFFF, acc(1, 0, 1, 0, 1), flg(0, 1), 32'h8, 2'd0, EX, 2'd3, 3'd0, "R6 code no check");
    // priority
    runReq(32'h0, 20'hFFF, acc(1, 0, 0, 0, 0), flg(0, 1), 32'h8, 2'd0, WR, 2'd3, 3'd2, "R10 type over priv");
    runReq(32'h0, 20'h0FF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'h800, 2'd0, RD, 2'd3, 3'd3, "R10 priv over limit");
  endtask

  task automatic testByteLimit;
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'hFFC, 2'd2, RD, 2'd0, 3'd0, "R7 edge in");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'hFFD, 2'd2, RD, 2'd0, 3'd4, "R7 edge out");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'hFF8, 2'd3, RD, 2'd0, 3'd0, "R7 eight in");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 0, 1), flg(0, 1), 32'hFF9, 2'd3, RD, 2'd0, 3'd4, "R7 eight out");
  endtask

  task automatic testPage;
    runReq(32'h0, 20'h00001, acc(1, 0, 0, 0, 1), flg(1, 1), 32'h1FFF, 2'd0, RD, 2'd0, 3'd0, "R8 page in");
    runReq(32'h0, 20'h00001, acc(1, 0, 0, 0, 1), flg(1, 1), 32'h2000, 2'd0, RD, 2'd0, 3'd4, "R8 page out");
    runReq(32'h0, 20'hFFFFF, acc(1, 0, 0, 0, 1), flg(1, 1), 32'hFFFF_FFFC, 2'd2, RD, 2'd0, 3'd0, "R8 full top");
    runReq(32'h0, 20'hFFFFF, acc(1, 0, 0, 0, 1), flg(1, 1), 32'hFFFF_FFFD, 2'd2, RD, 2'd0, 3'd4, "R8 full carry");
  endtask

  task automatic testGrowDown;
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 1, 1), flg(0, 0), 32'h1000, 2'd0, RD, 2'd0, 3'd0, "R9 above limit");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 1, 1), flg(0, 0), 32'h0FFF, 2'd0, RD, 2'd0, 3'd4, "R9 at limit");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 1, 1), flg(0, 0), 32'hFFFE, 2'd1, RD, 2'd0, 3'd0, "R9 narrow top in");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 1, 1), flg(0, 0), 32'hFFFF, 2'd1, RD, 2'd0, 3'd4, "R9 narrow top out");
    runReq(32'h0, 20'h00FFF, acc(1, 0, 0, 1, 1), flg(0, 1), 32'hFFFF, 2'd1, RD, 2'd0, 3'd0, "R9 wide top");
    runReq(32'h0, 20'h00001, acc(1, 0, 0, 1, 1), flg(1, 1), 32'h1FFF, 2'd0, RD, 2'd0, 3'd4, "R9 page limit");
  endtask

  task automatic testAddr;
    runReq(32'hF000_0000, 20'hFFFFF, acc(1, 0, 0, 0, 1), flg(1, 1), 32'h2000_0000, 2'd2, WR, 2'd0, 3'd0, "R11 wrap");
    runReq(32'h1234_5678, 20'hFFFFF, acc(1, 0, 1, 0, 0), flg(1, 1), 32'h0000_1111, 2'd0, EX, 2'd0, 3'd0, "R11 sum");
    runReq(32'h1234_5678, 20'hFFFFF, acc(1, 0, 1, 0, 0), flg(1, 1), 32'h0000_1111, 2'd0, WR, 2'd0, 3'd2, "R11 zero on fault");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLatency();
    testAbsent();
    testType();
    testCode();
    testData();
    testPriv();
    testByteLimit();
    testPage();
    testGrowDown();
    testAddr();
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule